// File: doc/BRIEF.md
# Sparse Hit Readout Sequencer

This block sits behind a 128-channel front end whose channels share one 12-bit ADC. Each channel's discriminator pulses a hit line. The block keeps a sticky request flag for each channel and stamps the flag with a free-running time count. It then walks only the flagged channels in ascending index order. For each one it starts one ADC conversion, packs the channel index, the time stamp and the converted energy into a 32-bit record, and shifts the record out as eight 4-bit nibbles.

Channels without a flag cost no cycles, because a masked priority pick jumps straight to the next flagged index. When a scan runs out of flagged channels, the block emits a one-cycle end-of-frame strobe.

The output belongs to a daisy chain. While the local engine is idle, nibbles from the previous chip are forwarded with one cycle of latency. A stall line tells the previous chip to hold while local records are being produced. A local scan never starts in the middle of an upstream frame.

Top module: `sparse_readout`

## Requirements
- R1: While rst is high and after its release, no flag is set, and out_valid_o, out_eof_o, adc_start_o and up_stall_o are low. Hits presented during reset leave no trace.
- R2: Every channel whose hit line is sampled high while its flag is clear produces exactly one record. A hit on a channel whose flag is already set is ignored, and the first time stamp is kept. The flag clears in the cycle the record's last nibble leaves.
- R3: Within a scan, channels are served in ascending index order. The adc_start_o pulse for the next channel comes exactly one cycle after the last nibble of the previous record is visible, whatever the index distance between the two channels.
- R4: The record layout is bits [31:25] = channel index, [24:12] = 13-bit time stamp, [11:0] = ADC energy. Nibbles leave most significant first, so bits [31:28] go first.
- R5: The eight nibbles of one record appear on eight consecutive cycles with out_valid_o high. This is 160 ns at a 50 MHz clock.
- R6: When a scan has no further flagged channel, out_eof_o pulses for one cycle, immediately after the last nibble of the final record, with out_valid_o low.
- R7: A hit that arrives during a scan at an index above the channel last served is read in the same scan. A hit at a lower index waits for a new scan that follows the end-of-frame strobe.
- R8: adc_start_o is a one-cycle pulse and carries the channel on adc_ch_o. The first adc_valid_i after it delivers the energy. An adc_valid_i at any other time is ignored.
- R9: While the engine is idle, up_nib_i, up_valid_i and up_eof_i appear on the outputs one cycle later. up_stall_o is high from the adc_start_o pulse until the engine returns to idle.
- R10: No scan starts while an upstream frame is open. A frame is open from an accepted up_valid_i until the cycle after up_eof_i.
- R11: The time stamp equals the number of rising clock edges with rst low that came before the edge that sampled the hit, modulo 2^13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 128 | Per-channel discriminator hit pulses |
| adc_start_o | output | 1 | One-cycle request to convert a channel |
| adc_ch_o | output | 7 | Channel to convert |
| adc_valid_i | input | 1 | Conversion result valid |
| adc_data_i | input | 12 | Conversion result |
| up_nib_i | input | 4 | Nibble from the previous chip |
| up_valid_i | input | 1 | Previous chip's nibble valid |
| up_eof_i | input | 1 | Previous chip's end-of-frame strobe |
| up_stall_o | output | 1 | Previous chip must hold its stream |
| out_nib_o | output | 4 | Output nibble |
| out_valid_o | output | 1 | Output nibble valid |
| out_eof_o | output | 1 | End-of-frame strobe |

## Verification
Several rules are checked by assertions on every cycle:
- the single-cycle ADC start, which only names a flagged channel at or above the scan pointer;
- the stall being up whenever a conversion is requested;
- the absence of starts inside an open upstream frame;
- the unbroken run of nibbles;
- the end-of-frame pulse following an empty pick;
- a cleared flag staying clear.

Other properties need scenarios:
- the exact content of each record, including the time stamp counted from reset;
- skipping of idle channels;
- the same-scan versus next-scan treatment of late hits;
- suppression of duplicate hits and stray ADC strobes;
- the ordering of forwarded and local frames.

// File: rtl/sro_pkg.sv
package sro_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_SEL   = 2'd3
  } sro_state_e;

endpackage

// File: rtl/sro_flag_bank.sv
module sro_flag_bank #(
  parameter int NUM_CH = 128,
  parameter int TIME_W = 13,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic              clr_en_i,
  input  logic [IDX_W-1:0]  clr_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [NUM_CH-1:0] flags_o,
  output logic [TIME_W-1:0] rd_time_o
);

  logic [TIME_W-1:0] tcount_q;
  logic [TIME_W-1:0] stamp_q [NUM_CH];
  logic [NUM_CH-1:0] flag_q;
  logic [NUM_CH-1:0] clr_vec;
  logic [NUM_CH-1:0] set_ok;

  // per-channel arm and clear decode; a hit in the clearing cycle re-arms
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign clr_vec[g] = clr_en_i && (clr_idx_i == IDX_W'(g));
    assign set_ok[g]  = hit_i[g] && (!flag_q[g] || clr_vec[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tcount_q <= '0;
      flag_q   <= '0;
    end else begin
      tcount_q <= tcount_q + 1'b1;
      for (int i = 0; i < NUM_CH; i++) begin
        if (set_ok[i])       flag_q[i] <= 1'b1;
        else if (clr_vec[i]) flag_q[i] <= 1'b0;
      end
    end
  end

  // time stamps need no reset: a stamp is read only while its flag is set
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (set_ok[i]) stamp_q[i] <= tcount_q;
    end
  end

  assign flags_o   = flag_q;
  assign rd_time_o = stamp_q[rd_idx_i];

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (clr_en_i && !hit_i[clr_idx_i]) |=> !flags_o[$past(clr_idx_i)]); // R2

endmodule

// File: rtl/sro_prio_pick.sv
module sro_prio_pick #(
  parameter int NUM_CH = 128,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic [NUM_CH-1:0] flags_i,
  input  logic [PTR_W-1:0]  base_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);

  logic [NUM_CH-1:0] elig;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_mask
    assign elig[g] = flags_i[g] && (PTR_W'(g) >= base_i);
  end

  // lowest eligible index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/sro_frame_tx.sv
module sro_frame_tx #(
  parameter int REC_W = 32,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [REC_W-1:0] word_i,
  input  logic             shift_i,
  input  logic             fwd_i,
  input  logic             eof_i,
  input  logic [NIB_W-1:0] up_nib_i,
  input  logic             up_valid_i,
  input  logic             up_eof_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             valid_o,
  output logic             eof_o
);

  logic [REC_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      nib_o   <= '0;
      valid_o <= 1'b0;
      eof_o   <= 1'b0;
    end else begin
      if (load_i)       sh_q <= word_i;
      else if (shift_i) sh_q <= sh_q << NIB_W;

      if (shift_i) begin
        nib_o   <= sh_q[REC_W-1 -: NIB_W];
        valid_o <= 1'b1;
        eof_o   <= 1'b0;
      end else if (fwd_i) begin
        nib_o   <= up_nib_i;
        valid_o <= up_valid_i;
        eof_o   <= up_eof_i;
      end else begin
        nib_o   <= '0;
        valid_o <= 1'b0;
        eof_o   <= eof_i;
      end
    end
  end

  AST_NIB_CONTIG: assert property (@(posedge clk) disable iff (rst)
    shift_i |=> valid_o); // R5

  AST_EOF_PULSE: assert property (@(posedge clk) disable iff (rst)
    eof_i |=> (eof_o && !valid_o)); // R6

endmodule

// File: rtl/sparse_readout.sv
module sparse_readout
  import sro_pkg::*;
#(
  parameter int NUM_CH = 128,
  parameter int ADC_W  = 12,
  parameter int TIME_W = 13,
  parameter int NIB_W  = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hit_i,
  output logic              adc_start_o,
  output logic [IDX_W-1:0]  adc_ch_o,
  input  logic              adc_valid_i,
  input  logic [ADC_W-1:0]  adc_data_i,
  input  logic [NIB_W-1:0]  up_nib_i,
  input  logic              up_valid_i,
  input  logic              up_eof_i,
  output logic              up_stall_o,
  output logic [NIB_W-1:0]  out_nib_o,
  output logic              out_valid_o,
  output logic              out_eof_o
);

  localparam int PTR_W = IDX_W + 1;
  localparam int REC_W = IDX_W + TIME_W + ADC_W;
  localparam int NIBS  = REC_W / NIB_W;
  localparam int CNT_W = $clog2(NIBS);
  localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(NIBS - 1);

  sro_state_e        state_q;
  logic [IDX_W-1:0]  cur_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              up_open_q;
  logic              start_q;
  logic [IDX_W-1:0]  ch_q;

  logic [NUM_CH-1:0] flags;
  logic [TIME_W-1:0] stamp;
  logic [PTR_W-1:0]  base;
  logic              pick_found;
  logic [IDX_W-1:0]  pick_idx;
  logic              launch;
  logic              load_rec;
  logic              shifting;
  logic              last_nib;
  logic              fwd;
  logic              scan_done;

  assign base      = (state_q == ST_IDLE) ? '0 : ptr_q;
  assign launch    = pick_found &&
                     (((state_q == ST_IDLE) && !up_open_q && !up_valid_i) ||
                      (state_q == ST_SEL));
  assign load_rec  = (state_q == ST_CONV) && adc_valid_i;
  assign shifting  = (state_q == ST_SHIFT);
  assign last_nib  = shifting && (cnt_q == LAST_NIB);
  assign fwd       = (state_q == ST_IDLE);
  assign scan_done = (state_q == ST_SEL) && !pick_found;

  sro_flag_bank #(
    .NUM_CH (NUM_CH),
    .TIME_W (TIME_W)
  ) u_flags (
    .clk       (clk),
    .rst       (rst),
    .hit_i     (hit_i),
    .clr_en_i  (last_nib),
    .clr_idx_i (cur_q),
    .rd_idx_i  (cur_q),
    .flags_o   (flags),
    .rd_time_o (stamp)
  );

  sro_prio_pick #(
    .NUM_CH (NUM_CH)
  ) u_pick (
    .flags_i (flags),
    .base_i  (base),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  sro_frame_tx #(
    .REC_W (REC_W),
    .NIB_W (NIB_W)
  ) u_tx (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_rec),
    .word_i     ({cur_q, stamp, adc_data_i}),
    .shift_i    (shifting),
    .fwd_i      (fwd),
    .eof_i      (scan_done),
    .up_nib_i   (up_nib_i),
    .up_valid_i (up_valid_i),
    .up_eof_i   (up_eof_i),
    .nib_o      (out_nib_o),
    .valid_o    (out_valid_o),
    .eof_o      (out_eof_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      ptr_q     <= '0;
      cnt_q     <= '0;
      up_open_q <= 1'b0;
      start_q   <= 1'b0;
      ch_q      <= '0;
    end else begin
      start_q <= 1'b0;
      if (launch) begin
        start_q <= 1'b1;
        ch_q    <= pick_idx;
        cur_q   <= pick_idx;
      end
      case (state_q)
        ST_IDLE: begin
          if (up_eof_i)        up_open_q <= 1'b0;
          else if (up_valid_i) up_open_q <= 1'b1;
          if (launch) state_q <= ST_CONV;
        end
        ST_SEL: begin
          if (launch) state_q <= ST_CONV;
          else        state_q <= ST_IDLE;
        end
        ST_CONV: begin
          if (adc_valid_i) begin
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
          end
        end
        ST_SHIFT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_NIB) begin
            ptr_q   <= {1'b0, cur_q} + 1'b1;
            state_q <= ST_SEL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign adc_start_o = start_q;
  assign adc_ch_o    = ch_q;
  assign up_stall_o  = (state_q != ST_IDLE);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    adc_start_o |=> !adc_start_o); // R8

  AST_START_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    adc_start_o |-> flags[adc_ch_o]); // R2

  AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (adc_start_o && ($past(state_q) == ST_SEL)) |-> ({1'b0, adc_ch_o} >= ptr_q)); // R3

  AST_STALL_OWN: assert property (@(posedge clk) disable iff (rst)
    adc_start_o |-> up_stall_o); // R9

  AST_NO_START_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    adc_start_o |-> !$past(up_open_q)); // R10

endmodule

// File: tb/tb_sparse_readout.sv
module tb_sparse_readout;

  localparam int NCH = 128;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] hit_v = '0;
  logic           adc_start;
  logic [6:0]     adc_ch;
  logic           adc_valid = 1'b0;
  logic [11:0]    adc_data = '0;
  logic [3:0]     up_nib = '0;
  logic           up_valid = 1'b0;
  logic           up_eof = 1'b0;
  logic           up_stall;
  logic [3:0]     out_nib;
  logic           out_valid;
  logic           out_eof;

  sparse_readout dut (
    .clk         (clk),
    .rst         (rst),
    .hit_i       (hit_v),
    .adc_start_o (adc_start),
    .adc_ch_o    (adc_ch),
    .adc_valid_i (adc_valid),
    .adc_data_i  (adc_data),
    .up_nib_i    (up_nib),
    .up_valid_i  (up_valid),
    .up_eof_i    (up_eof),
    .up_stall_o  (up_stall),
    .out_nib_o   (out_nib),
    .out_valid_o (out_valid),
    .out_eof_o   (out_eof)
  );

  always #10 clk = ~clk;

  int cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int hit_time [NCH];

  // monitor state
  logic [31:0] recs [64];
  int          rec_cyc [64];
  int          eof_at [64];
  int          start_cyc [64];
  int          rc = 0, ec = 0, sc = 0;
  int          ncnt = 0;
  logic [31:0] word = '0;
  bit          prev_valid = 0;
  int          gap_err = 0, eof_late = 0, stall_bad = 0;

  // ADC model state
  int  lat = 0;
  int  pend = 0;
  bit  stray_req = 0;

  function automatic logic [11:0] energy(input int ch);
    return 12'((ch * 37) + 341);
  endfunction

  function automatic logic [31:0] exp_rec(input int ch);
    return {7'(ch), 13'(hit_time[ch]), energy(ch)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (!prev_valid && ncnt != 0) gap_err++;
        word = {word[27:0], out_nib};
        ncnt++;
        if (ncnt == 8) begin
          if (rc < 64) begin
            recs[rc]    = word;
            rec_cyc[rc] = cyc;
          end
          rc++;
          ncnt = 0;
        end
      end
      if (out_eof) begin
        if (!prev_valid || out_valid) eof_late++;
        if (ec < 64) eof_at[ec] = rc;
        ec++;
      end
      if (adc_start) begin
        if (!up_stall) stall_bad++;
        if (sc < 64) start_cyc[sc] = cyc;
        sc++;
      end
      prev_valid = out_valid;
    end
  end

  // ADC model: result three cycles after the start pulse is seen
  initial begin
    forever begin
      @(negedge clk);
      adc_valid = 1'b0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          adc_valid = 1'b1;
          adc_data  = energy(pend);
        end
      end
      if (adc_start) begin
        pend = int'(adc_ch);
        lat  = 3;
      end
      if (stray_req) begin
        adc_valid = 1'b1;
        adc_data  = 12'hFFF;
        stray_req = 0;
      end
    end
  end

  task automatic hit3(input int a, input int b, input int c);
    @(negedge clk);
    hit_v = '0;
    if (a >= 0) begin hit_v[a] = 1'b1; hit_time[a] = cyc; end
    if (b >= 0) begin hit_v[b] = 1'b1; hit_time[b] = cyc; end
    if (c >= 0) begin hit_v[c] = 1'b1; hit_time[c] = cyc; end
    @(negedge clk);
    hit_v = '0;
  endtask

  task automatic wait_eof(input int n);
    int t = 0;
    while (ec < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
  endtask

  // upstream frame of 8 nibbles then eof; optional hit during nibble hit_at
  task automatic up_frame(input logic [31:0] w, input int hit_at, input int hit_ch);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 1) chk(out_valid && out_nib == w[31:28], "R9 forward latency",
                      {27'd0, out_valid, out_nib}, {28'd1, w[31:28]});
      up_valid = 1'b1;
      up_nib   = w[31 - 4*k -: 4];
      hit_v    = '0;
      if (k == hit_at) begin
        hit_v[hit_ch]    = 1'b1;
        hit_time[hit_ch] = cyc;
      end
    end
    @(negedge clk);
    hit_v    = '0;
    up_valid = 1'b0;
    up_nib   = '0;
    up_eof   = 1'b1;
    @(negedge clk);
    up_eof = 1'b0;
  endtask

  localparam int VT [4][3] = '{
    '{3, 77, 127},
    '{0, -1, -1},
    '{64, 1, -1},
    '{126, 2, 90}
  };

  initial begin
    int rc0, ec0, sc0, t1;
    // ---- R1: reset state, hits during reset ignored
    hit_v[5]  = 1'b1;
    hit_v[60] = 1'b1;
    repeat (5) @(negedge clk);
    chk(!out_valid && !out_eof, "R1 outputs idle in reset", {30'd0, out_valid, out_eof}, 32'd0);
    chk(!adc_start && !up_stall, "R1 start/stall low in reset", {30'd0, adc_start, up_stall}, 32'd0);
    hit_v = '0;
    rst   = 1'b0;
    repeat (12) @(negedge clk);
    chk(sc == 0 && rc == 0, "R1 no activity after reset", sc, 32'd0);
    chk(!up_stall, "R1 stall low when idle", {31'd0, up_stall}, 32'd0);

    // ---- table of hit patterns (R2 R3 R4 R6 R11)
    for (int v = 0; v < 4; v++) begin
      int s [3];
      int n;
      n = 0;
      for (int j = 0; j < 3; j++) if (VT[v][j] >= 0) begin s[n] = VT[v][j]; n++; end
      for (int a = 0; a < n; a++)
        for (int b = 0; b < n - 1 - a; b++)
          if (s[b] > s[b+1]) begin int tmp; tmp = s[b]; s[b] = s[b+1]; s[b+1] = tmp; end
      rc0 = rc; ec0 = ec;
      hit3(VT[v][0], VT[v][1], VT[v][2]);
      wait_eof(ec0 + 1);
      chk(rc == rc0 + n, "R2 one record per hit channel", rc - rc0, n);
      for (int k = 0; k < n; k++)
        chk(recs[rc0+k] == exp_rec(s[k]), "R4 R11 R3 record content/order",
            recs[rc0+k], exp_rec(s[k]));
      chk(eof_at[ec0] == rc0 + n, "R6 eof after last record", eof_at[ec0], rc0 + n);
    end

    // ---- R3: idle channels cost no cycles
    rc0 = rc; ec0 = ec; sc0 = sc;
    hit3(2, 120, -1);
    wait_eof(ec0 + 1);
    chk(start_cyc[sc0+1] - rec_cyc[rc0] == 1, "R3 skip gap of idle channels",
        start_cyc[sc0+1] - rec_cyc[rc0], 32'd1);
    chk(recs[rc0+1] == exp_rec(120), "R3 far channel record", recs[rc0+1], exp_rec(120));

    // ---- R7: late hits above and below the scan position
    rc0 = rc; ec0 = ec; sc0 = sc;
    hit3(10, 100, -1);
    while (sc == sc0) @(negedge clk);
    hit3(50, 5, -1);
    wait_eof(ec0 + 2);
    chk(recs[rc0+1] == exp_rec(50), "R7 higher late hit in same scan", recs[rc0+1], exp_rec(50));
    chk(recs[rc0+2] == exp_rec(100), "R7 scan order kept", recs[rc0+2], exp_rec(100));
    chk(eof_at[ec0] == rc0 + 3, "R7 first scan ends after three", eof_at[ec0], rc0 + 3);
    chk(recs[rc0+3] == exp_rec(5), "R7 lower late hit in next scan", recs[rc0+3], exp_rec(5));
    chk(eof_at[ec0+1] == rc0 + 4, "R7 second scan eof", eof_at[ec0+1], rc0 + 4);

    // ---- R2: repeated hit while flagged is ignored
    rc0 = rc; ec0 = ec;
    hit3(20, -1, -1);
    t1 = hit_time[20];
    hit3(20, -1, -1);
    hit_time[20] = t1;
    wait_eof(ec0 + 1);
    chk(rc == rc0 + 1, "R2 duplicate hit gives one record", rc - rc0, 32'd1);
    chk(recs[rc0] == exp_rec(20), "R2 first time stamp kept", recs[rc0], exp_rec(20));

    // ---- R8: stray ADC strobe while idle is ignored
    rc0 = rc; ec0 = ec; sc0 = sc;
    stray_req = 1;
    repeat (4) @(negedge clk);
    chk(rc == rc0 && sc == sc0 && !out_valid, "R8 stray strobe no output", rc - rc0, 32'd0);
    hit3(9, -1, -1);
    wait_eof(ec0 + 1);
    chk(recs[rc0] == exp_rec(9), "R8 energy from matching strobe", recs[rc0], exp_rec(9));

    // ---- R9: pass-through while idle
    rc0 = rc; ec0 = ec;
    up_frame(32'hCAFE1234, -1, 0);
    repeat (3) @(negedge clk);
    chk(recs[rc0] == 32'hCAFE1234, "R9 forwarded frame", recs[rc0], 32'hCAFE1234);
    chk(ec == ec0 + 1, "R9 forwarded eof", ec - ec0, 32'd1);

    // ---- R10: local scan deferred during upstream frame
    rc0 = rc; ec0 = ec; sc0 = sc;
    up_frame(32'h13579BDF, 2, 33);
    chk(sc == sc0, "R10 no start inside upstream frame", sc - sc0, 32'd0);
    wait_eof(ec0 + 2);
    chk(recs[rc0] == 32'h13579BDF, "R10 upstream frame first", recs[rc0], 32'h13579BDF);
    chk(recs[rc0+1] == exp_rec(33), "R10 local record after", recs[rc0+1], exp_rec(33));

    // ---- global cycle checks
    chk(gap_err == 0, "R5 nibbles contiguous", gap_err, 32'd0);
    chk(eof_late == 0, "R6 eof adjacent to last nibble", eof_late, 32'd0);
    chk(stall_bad == 0, "R9 stall high during local readout", stall_bad, 32'd0);
    repeat (3) @(negedge clk);
    chk(!up_stall, "R9 stall released when idle", {31'd0, up_stall}, 32'd0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule